// File: doc/BRIEF.md
# Per-Pin Programmable Input Glitch Filter

This block conditions a bank of 32 asynchronous digital input pins before the rest of the chip treats them as input state. Each raw pin is first captured by a two-flop synchronizer on the bank clock. The synchronized level then passes through a per-pin glitch filter that runs on the same clock. The filtered level is held in one output register, and all filter levels share that register.

Each pin has its own filter strength, taken from a 2-bit field. The fields for pins 0 to 15 sit in one 32-bit configuration word, and the fields for pins 16 to 31 sit in a second word. A strength of "off" passes the synchronized level straight through. The other three strengths reject any synchronized pulse of at most 1, 3 or 8 clock cycles. A filtered pin adopts a new level only after that level has been seen on threshold+1 consecutive cycles. A change of a pin's strength restarts its qualification.

Top module: `gf_input_conditioner`

## Requirements
- R1: While `rst` is high, the synchronizer stages, the filter counters and `pin_state` are cleared, so `pin_state` reads all zeros.
- R2: A pin whose field is 00 (off) and whose field has not just changed copies the second synchronizer stage into `pin_state` through one register. A raw level that is held across a clock edge therefore appears on the output after the third rising edge.
- R3: Pin k (k < 16) takes its field from `cfg_lo[2k+1:2k]`, and pin 16+k takes its field from `cfg_hi[2k+1:2k]`. The encoding is 00 = off, 01 = reject at most 1 cycle, 10 = reject at most 3 cycles, 11 = reject at most 8 cycles.
- R4: With the field at 00, a one-cycle pulse on a raw pin appears on `pin_state`.
- R5: With the field at 01, a one-cycle pulse is rejected, and pulses of two cycles and of three cycles pass.
- R6: With the field at 10, a three-cycle pulse is rejected and a four-cycle pulse passes.
- R7: With the field at 11, pulses of three and of eight cycles are rejected and a nine-cycle pulse passes.
- R8: A filtered output changes only to the level the synchronizer held in the previous cycle, and only after that level was seen on threshold+1 consecutive cycles. The per-pin run counter never exceeds the threshold. Any cycle in which the synchronized level equals the output clears the counter.
- R9: In the cycle in which a pin's field changes, that pin's output holds and its counter restarts from zero. The new threshold must then be met in full.
- R10: Pins are filtered independently: the output of each pin depends only on its own raw input and its own field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock for the synchronizer and the filters |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 32 | Asynchronous raw pin levels |
| cfg_lo | input | 32 | Filter fields for pins 0 to 15, two bits per pin |
| cfg_hi | input | 32 | Filter fields for pins 16 to 31, two bits per pin |
| pin_state | output | 32 | Synchronized and filtered pin levels |

## Verification
The assertions check, on every cycle, that the outputs clear under reset, that an off pin tracks the second synchronizer stage one register later, and that a filtered output moves only towards the previous synchronized level. They also check that no output moves in a cycle in which its field changes, and that no counter runs past its threshold. The exact pulse lengths that pass or are rejected at each strength can only be shown by the bench's directed pulses. The same holds for the placement of the fields across the two words, the restart after a strength change, and the independence of the pins under random bursts. The bench compares these against a run-history model.

// File: rtl/gf_pkg.sv
package gf_pkg;

  // 2-bit per-pin filter strength
  typedef enum logic [1:0] {
    FLT_OFF   = 2'b00,
    FLT_SHORT = 2'b01,
    FLT_MID   = 2'b10,
    FLT_LONG  = 2'b11
  } flt_lvl_e;

  localparam int unsigned LVL_W     = 2;
  localparam int unsigned REJ_SHORT = 1;
  localparam int unsigned REJ_MID   = 3;
  localparam int unsigned REJ_LONG  = 8;
  localparam int unsigned CNT_W     = $clog2(REJ_LONG + 1);

  // longest synchronized pulse that a strength still rejects
  function automatic int unsigned reject_len(flt_lvl_e lvl);
    case (lvl)
      FLT_SHORT: return REJ_SHORT;
      FLT_MID:   return REJ_MID;
      FLT_LONG:  return REJ_LONG;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gf_cfg_decode.sv
module gf_cfg_decode
  import gf_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned HALF  = NPINS / 2,
  localparam int unsigned CFG_W = HALF * LVL_W
) (
  input  logic [CFG_W-1:0] cfg_lo,
  input  logic [CFG_W-1:0] cfg_hi,
  output flt_lvl_e         lvl [NPINS]
);

  for (genvar k = 0; k < HALF; k++) begin : g_field
    assign lvl[k]      = flt_lvl_e'(cfg_lo[k*LVL_W +: LVL_W]);
    assign lvl[HALF+k] = flt_lvl_e'(cfg_hi[k*LVL_W +: LVL_W]);
  end

endmodule

// File: rtl/gf_pin_filter.sv
module gf_pin_filter
  import gf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  flt_lvl_e         lvl,
  output logic             filt_out,
  output logic             lvl_chg,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] limit
);

  flt_lvl_e         lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             out_q;
  logic             differs;
  logic             qualified;

  assign limit     = CNT_W'(reject_len(lvl));
  assign lvl_chg   = (lvl != lvl_q);
  assign differs   = (sync_in != out_q);
  assign qualified = differs && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= FLT_OFF;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (lvl_chg || !differs) begin
        cnt_q <= '0;
      end else if (qualified) begin
        out_q <= sync_in;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_out = out_q;
  assign cnt      = cnt_q;

endmodule

// File: rtl/gf_input_conditioner.sv
module gf_input_conditioner
  import gf_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned HALF  = NPINS / 2,
  localparam int unsigned CFG_W = HALF * LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_raw,
  input  logic [CFG_W-1:0] cfg_lo,
  input  logic [CFG_W-1:0] cfg_hi,
  output logic [NPINS-1:0] pin_state
);

  logic [NPINS-1:0]       sync_q;
  logic [NPINS-1:0]       lvl_chg;
  logic [NPINS-1:0]       bypass_m;
  logic [NPINS*CNT_W-1:0] cnt_flat;
  logic [NPINS*CNT_W-1:0] lim_flat;
  flt_lvl_e               lvl [NPINS];

  gf_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (sync_q)
  );

  gf_cfg_decode #(.NPINS(NPINS)) u_dec (
    .cfg_lo (cfg_lo),
    .cfg_hi (cfg_hi),
    .lvl    (lvl)
  );

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    assign bypass_m[k] = (lvl[k] == FLT_OFF);
    gf_pin_filter u_flt (
      .clk      (clk),
      .rst      (rst),
      .sync_in  (sync_q[k]),
      .lvl      (lvl[k]),
      .filt_out (pin_state[k]),
      .lvl_chg  (lvl_chg[k]),
      .cnt      (cnt_flat[k*CNT_W +: CNT_W]),
      .limit    (lim_flat[k*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/gf_input_conditioner_chk.sv
module gf_input_conditioner_chk
  import gf_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NPINS-1:0]       sync_q,
  input logic [NPINS-1:0]       pin_state,
  input logic [NPINS-1:0]       lvl_chg,
  input logic [NPINS-1:0]       bypass_m,
  input logic [NPINS*CNT_W-1:0] cnt_flat,
  input logic [NPINS*CNT_W-1:0] lim_flat
);

  // R1: reset clears the output and the synchronizer
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pin_state == '0 && sync_q == '0));

  // R2: an off pin tracks the second stage one register later
  a_r2_bypass_path: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_state ^ $past(sync_q)) & $past(bypass_m & ~lvl_chg)) == '0));

  // R8: an output moves only to the previous synchronized level
  a_r8_follow_sync: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_state ^ $past(pin_state)) & (pin_state ^ $past(sync_q))) == '0));

  // R9: no output moves in a cycle in which its field changed
  a_r9_hold_on_change: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pin_state ^ $past(pin_state)) & $past(lvl_chg)) == '0));

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    // R8: the run counter stays within its threshold
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
      !lvl_chg[k] |-> (cnt_flat[k*CNT_W +: CNT_W] <= lim_flat[k*CNT_W +: CNT_W]));
  end

endmodule

bind gf_input_conditioner gf_input_conditioner_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_q    (sync_q),
  .pin_state (pin_state),
  .lvl_chg   (lvl_chg),
  .bypass_m  (bypass_m),
  .cnt_flat  (cnt_flat),
  .lim_flat  (lim_flat)
);

// File: tb/test_gf_input_conditioner.sv
module test_gf_input_conditioner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_raw = '0;
  logic [31:0] cfg_lo = '0;
  logic [31:0] cfg_hi = '0;
  logic [31:0] pin_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  gf_input_conditioner i_gf_input_conditioner (
    .clk(clk), .rst(rst), .pin_raw(pin_raw),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .pin_state(pin_state)
  );

  // field code -> longest rejected pulse (R3 encoding)
  function automatic int rej(logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return 3;
      default: return 8;
    endcase
  endfunction

  function automatic logic [1:0] field_of(int k);
    if (k < 16) return cfg_lo[2*k +: 2];
    return cfg_hi[2*(k-16) +: 2];
  endfunction

  function automatic bit should_pass(logic [1:0] c, int len);
    return len > rej(c);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // run-history reference model
  logic [31:0] m_s1, m_s2, m_out;
  logic [8:0]  m_hist [32];
  int          m_age  [32];
  logic [1:0]  m_prev [32];

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_out <= '0;
      for (int k = 0; k < 32; k++) begin
        m_hist[k] <= '0; m_age[k] <= 15; m_prev[k] <= 2'd0;
      end
    end else begin
      m_s1 <= pin_raw;
      m_s2 <= m_s1;
      for (int k = 0; k < 32; k++) begin
        logic [1:0] cur;
        bit ok;
        int t;
        cur = field_of(k);
        if (cur != m_prev[k]) begin
          m_age[k] <= 0;
        end else begin
          t = rej(cur);
          ok = (m_s2[k] != m_out[k]) && (m_age[k] >= t);
          for (int j = 0; j < t; j++) if (m_hist[k][j] == m_out[k]) ok = 0;
          if (ok) m_out[k] <= m_s2[k];
          m_age[k] <= (m_age[k] < 15) ? m_age[k] + 1 : 15;
        end
        m_hist[k] <= {m_hist[k][7:0], m_s2[k]};
        m_prev[k] <= cur;
      end
    end
  end

  // R10: every cycle, every pin against the model
  always @(negedge clk) begin
    if (cmp_en && !rst) check(pin_state == m_out, "R10 model", pin_state, m_out);
  end

  task automatic set_field(int pin, logic [1:0] code);
    cfg_lo = '0; cfg_hi = '0;
    if (pin < 16) cfg_lo[2*pin +: 2] = code;
    else cfg_hi[2*(pin-16) +: 2] = code;
  endtask

  task automatic pulse_test(int pin, logic [1:0] code, int len, string req);
    bit seen;
    bit exp;
    set_field(pin, code);
    pin_raw = '0;
    repeat (14) @(negedge clk);
    pin_raw[pin] = 1'b1;
    repeat (len) @(negedge clk);
    pin_raw[pin] = 1'b0;
    seen = 0;
    repeat (22) begin
      @(negedge clk);
      if (pin_state[pin]) seen = 1;
    end
    exp = should_pass(code, len);
    check(seen == exp, req, 32'(seen), 32'(exp));
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hold [32];
    void'($urandom(32'h1d2c3b4a));
    pin_raw = '1;
    cfg_lo = 32'h5555_5555;
    repeat (4) @(negedge clk);
    check(pin_state == '0, "R1 reset", pin_state, 32'h0);
    pin_raw = '0; cfg_lo = '0;
    @(negedge clk);
    rst = 1'b0;
    cmp_en = 1;

    // R2: latency in bypass mode
    repeat (3) @(negedge clk);
    pin_raw[7] = 1'b1;
    repeat (2) @(negedge clk);
    check(pin_state[7] == 1'b0, "R2 two edges", pin_state, 32'h0);
    @(negedge clk);
    check(pin_state[7] == 1'b1, "R2 third edge", pin_state, 32'h80);
    pin_raw[7] = 1'b0;

    pulse_test(2,  2'b00, 1, "R4 off len1");
    pulse_test(9,  2'b01, 1, "R5 short len1");
    pulse_test(9,  2'b01, 2, "R5 short len2");
    pulse_test(18, 2'b01, 3, "R5 short len3");
    pulse_test(12, 2'b10, 3, "R6 mid len3");
    pulse_test(12, 2'b10, 4, "R6 mid len4");
    pulse_test(30, 2'b11, 3, "R7 long len3");
    pulse_test(30, 2'b11, 8, "R7 long len8");
    pulse_test(30, 2'b11, 9, "R7 long len9");
    pulse_test(15, 2'b11, 4, "R3 lo top field");
    pulse_test(31, 2'b10, 4, "R3 hi top field");
    pulse_test(21, 2'b11, 4, "R3 hi pin21");

    // R3: same field bits in both words steer different pins
    cfg_lo = '0; cfg_hi = '0; cfg_lo[11:10] = 2'b11;
    pin_raw = '0;
    repeat (14) @(negedge clk);
    pin_raw[5] = 1'b1; pin_raw[21] = 1'b1;
    @(negedge clk);
    pin_raw = '0;
    repeat (2) @(negedge clk);
    check(pin_state[21] == 1'b1 && pin_state[5] == 1'b0, "R3 split words",
          pin_state, 32'h0020_0000);

    // R9: a field change restarts the qualification
    set_field(0, 2'b11);
    repeat (14) @(negedge clk);
    pin_raw[0] = 1'b1;
    repeat (6) @(negedge clk);
    set_field(0, 2'b01);
    @(negedge clk);
    check(pin_state[0] == 1'b0, "R9 hold at change", pin_state, 32'h0);
    @(negedge clk);
    check(pin_state[0] == 1'b0, "R9 first new sample", pin_state, 32'h0);
    @(negedge clk);
    check(pin_state[0] == 1'b1, "R9 qualified", pin_state, 32'h1);
    pin_raw = '0;
    repeat (14) @(negedge clk);

    // R8 and R10: random bursts with mixed fields
    for (int k = 0; k < 32; k++) hold[k] = 1 + $urandom_range(11, 0);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (c % 250 == 0) begin
        cfg_lo = $urandom();
        cfg_hi = $urandom();
      end
      for (int k = 0; k < 32; k++) begin
        hold[k]--;
        if (hold[k] == 0) begin
          pin_raw[k] = ~pin_raw[k];
          hold[k] = 1 + $urandom_range(11, 0);
        end
      end
    end
    repeat (20) @(negedge clk);
    check(checks > 4000, "R8 random coverage", 32'(checks), 32'd4000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule